// File: doc/BRIEF.md
# Huffman Code Table Builder

This block turns a set of per-symbol occurrence counts into a prefix-code table for a 32-entry alphabet of 5-bit symbols. It builds no tree. Each symbol carries a group number. The block repeatedly takes the two live groups with the smallest total count and folds them into one. On each fold it puts one new leading bit in front of the code of every member symbol and adds one to that symbol's code length.

A host first writes 16-bit counts while the block is idle. It then pulses `start`. When the table is complete, `table_ready` rises and one 36-bit word per symbol streams out on consecutive cycles, in symbol order. The result is held until the host pulses `done`. The `done` pulse returns the block to idle and clears every count. Inputs the block cannot encode raise `error` instead of producing a table.

Top module: `huf_builder`

## Requirements
- R1: After reset, `table_ready`, `tbl_valid` and `error` are low.
- R2: While idle, a cycle with `load_en` high stores `load_freq` as the count of symbol `load_sym`. Every symbol with a nonzero count becomes its own group, numbered by its symbol value.
- R3: Each merge takes the two live groups with the smallest totals, and a tie goes to the lower group number. The merged group keeps the lower of the two numbers. Members of the lower-numbered group get a leading 0, members of the other group get a leading 1, and every member's length grows by one.
- R4: For counts 4, 7, 2, 1, 15 on symbols 0 to 4, the lengths are 3, 2, 4, 4, 1 and the code values are 0, 1, 2, 3, 1.
- R5: A table word holds the length in bits 35:31 and the code, right-aligned, in bits 30:0. The most recently added bit sits at position length-1. A symbol with a zero count reads as an all-zero word.
- R6: Readout gives 32 words on consecutive cycles with `tbl_valid` high, symbols 0 to 31 in order, each word tagged by `tbl_sym`. `table_ready` is high throughout the readout and stays high until `done`.
- R7: With n nonzero counts and no overflow, the first table word appears 2n+2 clock cycles after the edge that samples `start`.
- R8: When exactly one symbol has a nonzero count, it gets length 1 and code 0.
- R9: When every count is zero, `error` rises 3 cycles after the edge that samples `start`, and `table_ready` stays low.
- R10: A merge whose sum exceeds 16 bits saturates the group total to 0xFFFF, raises `error`, and ends the build without a table.
- R11: `done` returns the block to idle, clears `error`, and clears all counts, so a following start with no new loads reports an error.
- R12: `start` has no effect while a result is being held. No new readout follows, and `table_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write a symbol count (idle only) |
| load_sym | input | 5 | Symbol whose count is written |
| load_freq | input | 16 | Count value |
| start | input | 1 | Begin building the table |
| done | input | 1 | Release the held result or error, clear counts |
| table_ready | output | 1 | Table is being read out or is held |
| tbl_valid | output | 1 | `tbl_word` carries a table entry this cycle |
| tbl_sym | output | 5 | Symbol of the current table entry |
| tbl_word | output | 36 | Length (35:31) and code (30:0) |
| error | output | 1 | No symbol present or a count sum overflowed |

## Verification
The timing follows from the control sequence. Start is sampled on one edge. Initialisation takes one cycle, and every merge then costs one search cycle and one update cycle, with a final search and decision pass after the last merge. This puts the first table word 2n+2 edges after start, and places an error for an empty set 3 edges after start. The bench drives every input at the falling edge and counts rising edges from the start-sampling edge until `tbl_valid` or `error` is seen at a falling edge. It compares that count with the value the requirement gives. It collects the words by their `tbl_sym` tag. It compares each word against a table it computes itself from the merge rules, and against fixed values for the five-symbol example.

// File: rtl/huf_pkg.sv
package huf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_SEARCH,
        ST_MERGE,
        ST_EMIT,
        ST_HOLD,
        ST_FAULT
    } huf_state_e;

endpackage

// File: rtl/huf_min2.sv
module huf_min2 #(
    parameter int SYM_W  = 5,
    parameter int FREQ_W = 16,
    localparam int NSYM  = 1 << SYM_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  logic [NSYM-1:0]               live,
    input  logic [NSYM-1:0][FREQ_W-1:0]   freq,
    output logic [SYM_W-1:0]              lo,
    output logic [SYM_W-1:0]              hi,
    output logic [SYM_W:0]                cnt
);

    typedef struct packed {
        logic [SYM_W-1:0] lo;
        logic [SYM_W-1:0] hi;
        logic [SYM_W:0]   cnt;
    } pick_t;

    pick_t pick_d, pick_q;

    always_comb begin
        logic [FREQ_W:0]  f1;
        logic [FREQ_W:0]  f2;
        logic [SYM_W-1:0] i1;
        logic [SYM_W-1:0] i2;
        logic [FREQ_W:0]  fv;
        f1 = '1;
        f2 = '1;
        i1 = '0;
        i2 = '0;
        fv = '0;
        pick_d.cnt = '0;
        for (int i = 0; i < NSYM; i++) begin
            if (live[i]) begin
                fv = {1'b0, freq[i]};
                pick_d.cnt = pick_d.cnt + (SYM_W+1)'(1);
                if (fv < f1) begin
                    f2 = f1;
                    i2 = i1;
                    f1 = fv;
                    i1 = SYM_W'(i);
                end else if (fv < f2) begin
                    f2 = fv;
                    i2 = SYM_W'(i);
                end
            end
        end
        if (pick_d.cnt < (SYM_W+1)'(2)) begin
            pick_d.lo = i1;
            pick_d.hi = i1;
        end else if (i1 < i2) begin
            pick_d.lo = i1;
            pick_d.hi = i2;
        end else begin
            pick_d.lo = i2;
            pick_d.hi = i1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pick_q <= '0;
        end else if (en) begin
            pick_q <= pick_d;
        end
    end

    assign lo  = pick_q.lo;
    assign hi  = pick_q.hi;
    assign cnt = pick_q.cnt;

    // R3: a pair of distinct groups is reported lower number first
    a_r3_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (cnt < (SYM_W+1)'(2) || lo < hi));

    // R3: the chosen group is a live one
    a_r3_pick_live: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (cnt == '0 || live[lo]));

endmodule

// File: rtl/huf_freq.sv
module huf_freq #(
    parameter int SYM_W  = 5,
    parameter int FREQ_W = 16,
    localparam int NSYM  = 1 << SYM_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          load_en,
    input  logic [SYM_W-1:0]              load_sym,
    input  logic [FREQ_W-1:0]             load_freq,
    input  logic                          init,
    input  logic                          merge_en,
    input  logic [SYM_W-1:0]              lo,
    input  logic [SYM_W-1:0]              hi,
    output logic [NSYM-1:0][FREQ_W-1:0]   gfreq,
    output logic [NSYM-1:0]               live,
    output logic                          sum_ovf
);

    typedef struct packed {
        logic [NSYM-1:0][FREQ_W-1:0] f;
        logic [NSYM-1:0]             live;
    } fstore_t;

    fstore_t st_d, st_q;
    logic [FREQ_W:0] sum;

    assign sum     = {1'b0, st_q.f[lo]} + {1'b0, st_q.f[hi]};
    assign sum_ovf = sum[FREQ_W];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (load_en) begin
                st_d.f[load_sym] = load_freq;
            end
            if (init) begin
                for (int i = 0; i < NSYM; i++) begin
                    st_d.live[i] = (st_q.f[i] != '0);
                end
            end
            if (merge_en) begin
                st_d.f[lo]    = sum_ovf ? '1 : sum[FREQ_W-1:0];
                st_d.live[hi] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gfreq = st_q.f;
    assign live  = st_q.live;

    // R3: the higher-numbered group stops being live after a merge
    a_r3_retire_hi: assert property (@(posedge clk) disable iff (!rst_n)
        merge_en |=> !live[$past(hi)]);

    // R10: an overflowing sum leaves the merged total saturated
    a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (merge_en && sum_ovf) |=> gfreq[$past(lo)] == '1);

endmodule

// File: rtl/huf_table.sv
module huf_table #(
    parameter int SYM_W  = 5,
    localparam int NSYM   = 1 << SYM_W,
    localparam int CODE_W = NSYM - 1,
    localparam int LEN_W  = SYM_W,
    localparam int WORD_W = LEN_W + CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              merge_en,
    input  logic              single_en,
    input  logic [SYM_W-1:0]  lo,
    input  logic [SYM_W-1:0]  hi,
    input  logic [SYM_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);

    typedef struct packed {
        logic [NSYM-1:0][SYM_W-1:0]  grp;
        logic [NSYM-1:0][CODE_W-1:0] code;
        logic [NSYM-1:0][LEN_W-1:0]  len;
    } tbl_t;

    tbl_t tb_d, tb_q;

    always_comb begin
        tb_d = tb_q;
        if (init) begin
            for (int s = 0; s < NSYM; s++) begin
                tb_d.grp[s]  = SYM_W'(s);
                tb_d.code[s] = '0;
                tb_d.len[s]  = '0;
            end
        end else if (merge_en) begin
            for (int s = 0; s < NSYM; s++) begin
                if (tb_q.grp[s] == lo) begin
                    tb_d.len[s] = tb_q.len[s] + LEN_W'(1);
                end else if (tb_q.grp[s] == hi) begin
                    tb_d.code[s] = tb_q.code[s] | (CODE_W'(1) << tb_q.len[s]);
                    tb_d.len[s]  = tb_q.len[s] + LEN_W'(1);
                    tb_d.grp[s]  = lo;
                end
            end
        end else if (single_en) begin
            tb_d.len[lo]  = LEN_W'(1);
            tb_d.code[lo] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tb_q <= '0;
        end else begin
            tb_q <= tb_d;
        end
    end

    assign rd_word = {tb_q.len[rd_idx], tb_q.code[rd_idx]};

    // R3: the symbol naming the higher group joins the lower group
    a_r3_relabel: assert property (@(posedge clk) disable iff (!rst_n)
        merge_en |=> tb_q.grp[$past(hi)] == $past(lo));

    // R3: the lower group's own symbol gains one code bit
    a_r3_len_grow: assert property (@(posedge clk) disable iff (!rst_n)
        merge_en |=> tb_q.len[$past(lo)] == $past(tb_q.len[lo]) + LEN_W'(1));

    // R8: a lone symbol ends with a one-bit code
    a_r8_single_len: assert property (@(posedge clk) disable iff (!rst_n)
        single_en |=> tb_q.len[$past(lo)] == LEN_W'(1));

endmodule

// File: rtl/huf_builder.sv
module huf_builder
    import huf_pkg::*;
#(
    parameter int SYM_W  = 5,
    parameter int FREQ_W = 16,
    localparam int NSYM   = 1 << SYM_W,
    localparam int CODE_W = NSYM - 1,
    localparam int LEN_W  = SYM_W,
    localparam int WORD_W = LEN_W + CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [SYM_W-1:0]  load_sym,
    input  logic [FREQ_W-1:0] load_freq,
    input  logic              start,
    input  logic              done,
    output logic              table_ready,
    output logic              tbl_valid,
    output logic [SYM_W-1:0]  tbl_sym,
    output logic [WORD_W-1:0] tbl_word,
    output logic              error
);

    typedef struct packed {
        huf_state_e        st;
        logic [SYM_W-1:0]  idx;
        logic              vld;
        logic [SYM_W-1:0]  sym;
        logic [WORD_W-1:0] word;
        logic              err;
    } ctl_t;

    ctl_t c_d, c_q;

    logic                        init_p, srch_en, merge_en, single_en, clr_p, load_ok;
    logic [SYM_W-1:0]            lo, hi, rd_idx;
    logic [SYM_W:0]              cnt;
    logic [NSYM-1:0][FREQ_W-1:0] gfreq;
    logic [NSYM-1:0]             live;
    logic                        sum_ovf;
    logic [WORD_W-1:0]           rd_word;
    logic [LEN_W-1:0]            rd_len;

    assign rd_len  = rd_word[WORD_W-1 -: LEN_W];
    assign rd_idx  = (c_q.st == ST_EMIT) ? c_q.idx : lo;
    assign load_ok = load_en && (c_q.st == ST_IDLE);

    always_comb begin
        c_d       = c_q;
        c_d.vld   = 1'b0;
        init_p    = 1'b0;
        srch_en   = 1'b0;
        merge_en  = 1'b0;
        single_en = 1'b0;
        clr_p     = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (start) c_d.st = ST_INIT;
            end
            ST_INIT: begin
                init_p = 1'b1;
                c_d.st = ST_SEARCH;
            end
            ST_SEARCH: begin
                srch_en = 1'b1;
                c_d.st  = ST_MERGE;
            end
            ST_MERGE: begin
                if (cnt == '0) begin
                    c_d.err = 1'b1;
                    c_d.st  = ST_FAULT;
                end else if (cnt == (SYM_W+1)'(1)) begin
                    single_en = (rd_len == '0);
                    c_d.idx   = '0;
                    c_d.st    = ST_EMIT;
                end else begin
                    merge_en = 1'b1;
                    if (sum_ovf) begin
                        c_d.err = 1'b1;
                        c_d.st  = ST_FAULT;
                    end else begin
                        c_d.st = ST_SEARCH;
                    end
                end
            end
            ST_EMIT: begin
                c_d.vld  = 1'b1;
                c_d.sym  = c_q.idx;
                c_d.word = rd_word;
                c_d.idx  = c_q.idx + SYM_W'(1);
                if (c_q.idx == SYM_W'(NSYM - 1)) c_d.st = ST_HOLD;
            end
            ST_HOLD: begin
                if (done) begin
                    clr_p  = 1'b1;
                    c_d.st = ST_IDLE;
                end
            end
            ST_FAULT: begin
                if (done) begin
                    clr_p   = 1'b1;
                    c_d.err = 1'b0;
                    c_d.st  = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    huf_freq #(.SYM_W(SYM_W), .FREQ_W(FREQ_W)) u_freq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_p),
        .load_en  (load_ok),
        .load_sym (load_sym),
        .load_freq(load_freq),
        .init     (init_p),
        .merge_en (merge_en),
        .lo       (lo),
        .hi       (hi),
        .gfreq    (gfreq),
        .live     (live),
        .sum_ovf  (sum_ovf)
    );

    huf_min2 #(.SYM_W(SYM_W), .FREQ_W(FREQ_W)) u_min2 (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (srch_en),
        .live (live),
        .freq (gfreq),
        .lo   (lo),
        .hi   (hi),
        .cnt  (cnt)
    );

    huf_table #(.SYM_W(SYM_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (init_p),
        .merge_en (merge_en),
        .single_en(single_en),
        .lo       (lo),
        .hi       (hi),
        .rd_idx   (rd_idx),
        .rd_word  (rd_word)
    );

    assign table_ready = (c_q.st == ST_EMIT) || (c_q.st == ST_HOLD);
    assign tbl_valid   = c_q.vld;
    assign tbl_sym     = c_q.sym;
    assign tbl_word    = c_q.word;
    assign error       = c_q.err;

    // R6: table words appear only while the table is ready
    a_r6_valid_ready: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_valid |-> table_ready);

    // R6: consecutive words step through the symbols in order
    a_r6_sym_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_valid && $past(tbl_valid)) |-> tbl_sym == $past(tbl_sym) + SYM_W'(1));

    // R9: an error never comes with a ready table
    a_r9_err_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !table_ready);

endmodule

// File: tb/huf_builder_test.sv
`timescale 1ns/1ps
module huf_builder_test;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [4:0]  load_sym = '0;
    logic [15:0] load_freq = '0;
    logic        start = 1'b0;
    logic        done = 1'b0;
    logic        table_ready, tbl_valid, error;
    logic [4:0]  tbl_sym;
    logic [35:0] tbl_word;

    int checks = 0;
    int errors = 0;

    logic [15:0] fset [32];
    logic [35:0] exp_w [32];
    logic [35:0] got_w [32];
    int          exp_n;
    bit          exp_err;

    always #(HALF) clk = ~clk;

    huf_builder uut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_sym(load_sym),
        .load_freq(load_freq), .start(start), .done(done),
        .table_ready(table_ready), .tbl_valid(tbl_valid), .tbl_sym(tbl_sym),
        .tbl_word(tbl_word), .error(error)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(HALF * 2 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    // Reference table from the merge rules (R3, R5, R8, R9, R10)
    task automatic model();
        int gf [32];
        int grp [32];
        bit lv [32];
        logic [30:0] cd [32];
        int ln [32];
        bit stop;
        exp_n = 0;
        exp_err = 0;
        stop = 0;
        for (int i = 0; i < 32; i++) begin
            gf[i] = fset[i]; grp[i] = i; lv[i] = (fset[i] != 0); cd[i] = '0; ln[i] = 0;
            if (lv[i]) exp_n++;
        end
        if (exp_n == 0) exp_err = 1;
        else if (exp_n == 1) begin
            for (int i = 0; i < 32; i++) if (lv[i]) ln[i] = 1;
        end else begin
            for (int m = 0; m < exp_n - 1; m++) begin
                int f1, f2, i1, i2, lo, hi;
                if (!stop) begin
                    f1 = 32'h7fffffff; f2 = 32'h7fffffff; i1 = 0; i2 = 0;
                    for (int i = 0; i < 32; i++) begin
                        if (lv[i]) begin
                            if (gf[i] < f1) begin f2 = f1; i2 = i1; f1 = gf[i]; i1 = i; end
                            else if (gf[i] < f2) begin f2 = gf[i]; i2 = i; end
                        end
                    end
                    lo = (i1 < i2) ? i1 : i2;
                    hi = (i1 < i2) ? i2 : i1;
                    if (gf[lo] + gf[hi] > 65535) begin
                        exp_err = 1;
                        stop = 1;
                    end else begin
                        gf[lo] = gf[lo] + gf[hi];
                        lv[hi] = 0;
                        for (int s = 0; s < 32; s++) begin
                            if (grp[s] == lo) ln[s]++;
                            else if (grp[s] == hi) begin
                                cd[s] = cd[s] | (31'd1 << ln[s]);
                                ln[s]++;
                                grp[s] = lo;
                            end
                        end
                    end
                end
            end
        end
        for (int i = 0; i < 32; i++) exp_w[i] = {ln[i][4:0], cd[i]};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load_set();
        for (int i = 0; i < 32; i++) begin
            if (fset[i] != 0) begin
                @(negedge clk);
                load_en = 1'b1; load_sym = 5'(i); load_freq = fset[i];
            end
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic release_done();
        @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        check(!error && !table_ready, "R11 idle after done", {error, table_ready}, 0);
    endtask

    // pulse start, return number of edges counted until valid or error
    task automatic pulse_start(output int cyc);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        cyc = 1;
        @(negedge clk);
        start = 1'b0;
        while (!tbl_valid && !error && cyc < 200) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic build_and_compare(input string tag);
        int cyc, k;
        model();
        load_set();
        pulse_start(cyc);
        check(cyc == 2 * exp_n + 3, "R7 latency", cyc, 2 * exp_n + 3);
        k = 0;
        while (tbl_valid) begin
            check(tbl_sym == 5'(k), "R6 symbol order", tbl_sym, k);
            check(table_ready, "R6 ready during readout", table_ready, 1);
            got_w[tbl_sym] = tbl_word;
            k++;
            @(negedge clk);
        end
        check(k == 32, "R6 word count", k, 32);
        check(table_ready && !error, "R6 ready held", {table_ready, error}, 2);
        for (int i = 0; i < 32; i++)
            check(got_w[i] === exp_w[i], {"R3 R5 table ", tag}, got_w[i], exp_w[i]);
    endtask

    task automatic clear_set();
        for (int i = 0; i < 32; i++) fset[i] = 16'd0;
    endtask

    task automatic t_reset();
        check(!table_ready && !tbl_valid && !error, "R1 reset outputs",
              {table_ready, tbl_valid, error}, 0);
    endtask

    task automatic t_example();
        logic [35:0] fixed [5];
        clear_set();
        fset[0] = 4; fset[1] = 7; fset[2] = 2; fset[3] = 1; fset[4] = 15;
        build_and_compare("example");
        fixed[0] = {5'd3, 31'd0}; fixed[1] = {5'd2, 31'd1}; fixed[2] = {5'd4, 31'd2};
        fixed[3] = {5'd4, 31'd3}; fixed[4] = {5'd1, 31'd1};
        for (int i = 0; i < 5; i++) check(got_w[i] === fixed[i], "R4 example code", got_w[i], fixed[i]);
        for (int i = 5; i < 32; i++) check(got_w[i] === 36'd0, "R5 absent symbol", got_w[i], 0);
        release_done();
    endtask

    task automatic t_hold_ignores_start();
        int cyc, seen;
        clear_set();
        fset[3] = 10; fset[20] = 30;
        build_and_compare("hold");
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (tbl_valid || !table_ready) seen++;
        end
        check(seen == 0, "R12 start ignored in hold", seen, 0);
        cyc = 0;
        release_done();
    endtask

    task automatic t_single();
        clear_set();
        fset[9] = 5;
        build_and_compare("single");
        check(got_w[9] === {5'd1, 31'd0}, "R8 lone symbol", got_w[9], {5'd1, 31'd0});
        release_done();
    endtask

    task automatic t_ties();
        clear_set();
        for (int i = 0; i < 32; i++) fset[i] = 16'd100;
        build_and_compare("ties");
        for (int i = 0; i < 32; i++) check(got_w[i][35:31] == 5'd5, "R3 equal counts length", got_w[i][35:31], 5);
        release_done();
    endtask

    task automatic t_skewed();
        clear_set();
        fset[0] = 1;
        for (int i = 1; i < 16; i++) fset[i] = 16'(1 << (i - 1));
        build_and_compare("skewed");
        check(got_w[15][35:31] == 5'd1, "R3 heaviest length", got_w[15][35:31], 1);
        check(got_w[0][35:31] == 5'd15, "R3 lightest length", got_w[0][35:31], 15);
        release_done();
    endtask

    task automatic t_mixed();
        clear_set();
        for (int i = 0; i < 32; i++) fset[i] = 16'((i * 37) % 61 + 1);
        fset[6] = 0;
        build_and_compare("mixed");
        release_done();
    endtask

    task automatic t_empty();
        int cyc;
        clear_set();
        pulse_start(cyc);
        check(error == 1'b1, "R9 empty error", error, 1);
        check(cyc == 4, "R9 error timing", cyc, 4);
        check(!table_ready && !tbl_valid, "R9 no table", {table_ready, tbl_valid}, 0);
        release_done();
    endtask

    task automatic t_overflow();
        int cyc;
        clear_set();
        fset[0] = 16'hFFFF; fset[1] = 16'd1;
        load_set();
        pulse_start(cyc);
        check(error == 1'b1, "R10 overflow error", error, 1);
        check(!table_ready && !tbl_valid, "R10 no table", {table_ready, tbl_valid}, 0);
        release_done();
    endtask

    task automatic t_cleared_after_done();
        int cyc;
        clear_set();
        fset[2] = 8; fset[5] = 9;
        build_and_compare("reuse");
        release_done();
        pulse_start(cyc);
        check(error == 1'b1, "R11 counts cleared by done", error, 1);
        release_done();
    endtask

    task automatic t_load_idle();
        clear_set();
        fset[31] = 16'd2; fset[0] = 16'd2; fset[16] = 16'd3;
        build_and_compare("R2 loads");
        check(got_w[0] === {5'd2, 31'd0}, "R2 loaded count used", got_w[0], {5'd2, 31'd0});
        release_done();
    endtask

    initial begin
        do_reset();
        t_reset();
        t_example();
        t_hold_ignores_start();
        t_single();
        t_ties();
        t_skewed();
        t_mixed();
        t_empty();
        t_overflow();
        t_cleared_after_done();
        t_load_idle();
        summary();
        $finish;
    end

endmodule